// File: doc/BRIEF.md
# Character-Cell VGA Text Controller

This block generates 640x480 60 Hz VGA timing for a text display of 80 columns by 30 rows, each character cell being 8 pixels wide and 16 scanlines tall. It runs on the pixel clock, which is nominally about 25.2 MHz. Horizontal position is kept in byte times of 8 pixel clocks. Both the byte counter and the line counter are zero on the first visible byte and line. As a result, the character column, character row and glyph scanline come straight from the counter bits.

The controller reads an external character memory by cell address, one byte time before that cell is shown. It passes the returned character code to an external glyph lookup, together with the scanline number. The memory and the lookup each have one registered cycle of latency. The 8-bit glyph row that comes back is loaded into a shift register and sent out one pixel per clock, most significant bit first. The syncs and the display enable are registered so that they stay aligned with that pixel stream. Font contents, colour and the character memory itself are outside the block.

Top module: `vga_text_top`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP byte times of 8 pixel clocks each (100 byte times, 800 clocks, by default). The byte counter advances only on the eighth clock of a byte and wraps from its last value to 0.
- R2: `hsync_n` is low for exactly the H_SYNC byte times that start at byte H_ACTIVE+H_FP (bytes 82 to 93 by default). It is high at every other byte.
- R3: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (524 by default). The line counter advances only when the byte counter wraps, and it wraps from its last value to 0.
- R4: `vsync_n` is low for exactly the V_SYNC lines that start at line V_ACTIVE+V_FP (lines 491 and 492 by default). It goes low on pixel clock 0 of byte 0 of the first of those lines.
- R5: `de` is high exactly when the byte is below H_ACTIVE and the line is below V_ACTIVE. It is never high while either sync is low.
- R6: During every clock of byte time h, `char_addr` shows the address of the next byte position: (line/16)*H_ACTIVE + column. After the last byte of a line, the next position is column 0 of the following line, and after the last line it is line 0. When the next position is outside the active area, `char_addr` is 0.
- R7: `glyph_line` is the next byte position's line modulo 16, that is, its low 4 bits. `glyph_code` equals `char_code` in the same cycle.
- R8: In an active byte, `pixel` on clock p (0 to 7) of the byte is bit 7-p of the glyph row for the character at that cell and scanline. This holds when `char_code` follows `char_addr` one clock later and `glyph_row` follows `glyph_code`/`glyph_line` one clock later.
- R9: `pixel` is 0 whenever `de` is low, and in particular whenever a sync is low.
- R10: While `rst_n` is low, both counters and the shift register are cleared. The outputs then show byte 0 of line 0: `de` is 1, both syncs are 1 and `pixel` is 0. The first byte after reset is shown blank, and glyph pixels start from the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_addr | output | AW = clog2(H_ACTIVE*V_ACTIVE/16) | Cell address for the next byte time |
| char_code | input | 8 | Character code returned by the memory, one clock after the address |
| glyph_code | output | 8 | Character code sent to the glyph lookup |
| glyph_line | output | clog2(GLYPH_H) | Scanline within the glyph sent to the glyph lookup |
| glyph_row | input | 8 | Glyph row returned by the lookup, one clock after the code |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable |
| pixel | output | 1 | Serial pixel, 1 = foreground |

## Verification
The hardest cases to reach are the prefetch boundaries. Column 0 of a line must be fetched during the last byte of the previous line. Column 0 of line 0 must be fetched during the last byte of the frame. The very first byte after reset has no prefetch at all. The bench shrinks the geometry to 4 columns by 2 rows with short porches, so a full frame takes only 2368 clocks. It then checks every clock across several frames, which crosses each line and frame wrap many times. A reset applied in the middle of a frame brings back the blank first byte and the restart from position zero.

// File: rtl/vga_text_pkg.sv
// Shared constants and types for the character-cell text controller.
// Assumes glyphs are exactly one byte wide (8 pixels per byte time).
package vga_text_pkg;
    localparam int unsigned CELL_PX = 8;
    localparam int unsigned PX_W    = $clog2(CELL_PX);

    typedef logic [CELL_PX-1:0] glyph_row_t;
    typedef logic [7:0]         char_code_t;
    typedef logic [PX_W-1:0]    px_cnt_t;
endpackage

// File: rtl/vga_scan_timer.sv
// Raster position counters: pixel-within-byte, byte-within-line and line.
// Also gives the position of the next clock and of the next byte time.
// Assumes H_TOTAL and V_TOTAL are at least 2.
module vga_scan_timer
    import vga_text_pkg::*;
#(
    parameter int unsigned H_TOTAL = 100,
    parameter int unsigned V_TOTAL = 524,
    parameter int unsigned HW      = $clog2(H_TOTAL),
    parameter int unsigned VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output px_cnt_t       px,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          px_last,
    output logic [HW-1:0] h_nxt,
    output logic [VW-1:0] v_nxt,
    output logic [HW-1:0] h_up,
    output logic [VW-1:0] v_up
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam px_cnt_t       PX_END = px_cnt_t'(CELL_PX - 1);

    logic line_end;

    // Work out the next byte position and the next clock's position.
    always_comb begin
        px_last  = (px == PX_END);
        line_end = (hcnt == H_LAST);
        h_up     = line_end ? '0 : hcnt + 1'b1;
        if (line_end) v_up = (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        else          v_up = vcnt;
        h_nxt    = px_last ? h_up : hcnt;
        v_nxt    = px_last ? v_up : vcnt;
    end

    // Advance the counters one pixel clock at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px   <= '0;
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            px   <= px + 1'b1;
            hcnt <= h_nxt;
            vcnt <= v_nxt;
        end
    end

    // R1
    h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !px_last |=> $stable(hcnt));
    // R3
    v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(px_last && hcnt == H_LAST) |=> $stable(vcnt));
    // R3
    v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_last && hcnt == H_LAST && vcnt == V_LAST) |=> (vcnt == '0 && hcnt == '0));
endmodule

// File: rtl/vga_sync_gen.sv
// Registered sync and display-enable outputs, decoded from the position
// of the next clock so that they line up with the current counters.
// Assumes a nonzero active area and that sync follows a nonzero front porch.
module vga_sync_gen
    import vga_text_pkg::*;
#(
    parameter int unsigned H_ACTIVE = 80,
    parameter int unsigned H_FP     = 2,
    parameter int unsigned H_SYNC   = 12,
    parameter int unsigned V_ACTIVE = 480,
    parameter int unsigned V_FP     = 11,
    parameter int unsigned V_SYNC   = 2,
    parameter int unsigned HW       = 7,
    parameter int unsigned VW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  px_cnt_t       px,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic [HW-1:0] h_nxt,
    input  logic [VW-1:0] v_nxt,
    output logic          de,
    output logic          hs_n,
    output logic          vs_n
);
    localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
    localparam logic [HW-1:0] HS_LO  = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] HS_HI  = HW'(H_ACTIVE + H_FP + H_SYNC - 1);
    localparam logic [VW-1:0] VS_LO  = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] VS_HI  = VW'(V_ACTIVE + V_FP + V_SYNC - 1);

    // Register the region decode of the next position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de   <= 1'b1;
            hs_n <= 1'b1;
            vs_n <= 1'b1;
        end else begin
            de   <= (h_nxt < H_ACT) && (v_nxt < V_ACT);
            hs_n <= !((h_nxt >= HS_LO) && (h_nxt <= HS_HI));
            vs_n <= !((v_nxt >= VS_LO) && (v_nxt <= VS_HI));
        end
    end

    // R2
    hs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_n) |-> (hcnt == HS_LO && px == '0));
    // R4
    vs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_n) |-> (vcnt == VS_LO && hcnt == '0 && px == '0));
    // R5
    de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hs_n && vs_n));
endmodule

// File: rtl/vga_cell_fetch.sv
// Cell address and glyph scanline for the next byte time.
// Assumes GLYPH_H is a power of two and V_ACTIVE a multiple of it.
module vga_cell_fetch #(
    parameter int unsigned H_ACTIVE = 80,
    parameter int unsigned V_ACTIVE = 480,
    parameter int unsigned GLYPH_H  = 16,
    parameter int unsigned HW       = 7,
    parameter int unsigned VW       = 10,
    parameter int unsigned AW       = 12,
    parameter int unsigned LW       = $clog2(GLYPH_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_up,
    input  logic [VW-1:0] v_up,
    output logic [AW-1:0] char_addr,
    output logic [LW-1:0] glyph_line,
    output logic          up_active
);
    localparam int unsigned   CELLS = H_ACTIVE * (V_ACTIVE / GLYPH_H);
    localparam logic [HW-1:0] H_ACT = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT = VW'(V_ACTIVE);

    logic [VW-LW-1:0] row;

    // Row and column of the next byte map to a linear cell address.
    always_comb begin
        row        = v_up[VW-1:LW];
        glyph_line = v_up[LW-1:0];
        up_active  = (h_up < H_ACT) && (v_up < V_ACT);
        char_addr  = up_active ? (AW'(row) * AW'(H_ACTIVE) + AW'(h_up)) : '0;
    end

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(char_addr) < CELLS);
endmodule

// File: rtl/vga_glyph_shift.sv
// Byte-wide glyph shift register: loads on request, otherwise shifts left;
// the MSB is the current pixel, gated by display enable.
module vga_glyph_shift
    import vga_text_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  glyph_row_t row_in,
    input  logic       de,
    output logic       pixel
);
    glyph_row_t sr;

    // Load a new glyph row at a byte boundary, else shift one pixel out.
    always_ff @(posedge clk) begin
        if (!rst_n)    sr <= '0;
        else if (load) sr <= row_in;
        else           sr <= {sr[CELL_PX-2:0], 1'b0};
    end

    // Present the MSB only inside the active area.
    assign pixel = de & sr[CELL_PX-1];
endmodule

// File: rtl/vga_text_top.sv
// Character-cell VGA text controller: raster timing, one-byte-ahead cell
// fetch, glyph lookup hand-off and pixel serialisation.
// Assumes the character memory and glyph lookup each register one cycle.
module vga_text_top
    import vga_text_pkg::*;
#(
    parameter int unsigned H_ACTIVE = 80,
    parameter int unsigned H_FP     = 2,
    parameter int unsigned H_SYNC   = 12,
    parameter int unsigned H_BP     = 6,
    parameter int unsigned V_ACTIVE = 480,
    parameter int unsigned V_FP     = 11,
    parameter int unsigned V_SYNC   = 2,
    parameter int unsigned V_BP     = 31,
    parameter int unsigned GLYPH_H  = 16,
    localparam int unsigned H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int unsigned V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
    localparam int unsigned HW      = $clog2(H_TOTAL),
    localparam int unsigned VW      = $clog2(V_TOTAL),
    localparam int unsigned CELLS   = H_ACTIVE * (V_ACTIVE / GLYPH_H),
    localparam int unsigned AW      = $clog2(CELLS),
    localparam int unsigned LW      = $clog2(GLYPH_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] char_addr,
    input  logic [7:0]    char_code,
    output logic [7:0]    glyph_code,
    output logic [LW-1:0] glyph_line,
    input  logic [7:0]    glyph_row,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic          pixel
);
    px_cnt_t       px;
    logic [HW-1:0] hcnt, h_nxt, h_up;
    logic [VW-1:0] vcnt, v_nxt, v_up;
    logic          px_last, up_active, load;

    vga_scan_timer #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .px(px), .hcnt(hcnt), .vcnt(vcnt),
        .px_last(px_last), .h_nxt(h_nxt), .v_nxt(v_nxt),
        .h_up(h_up), .v_up(v_up)
    );

    vga_sync_gen #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC),
        .HW(HW), .VW(VW)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .px(px), .hcnt(hcnt), .vcnt(vcnt),
        .h_nxt(h_nxt), .v_nxt(v_nxt),
        .de(de), .hs_n(hsync_n), .vs_n(vsync_n)
    );

    vga_cell_fetch #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .GLYPH_H(GLYPH_H),
        .HW(HW), .VW(VW), .AW(AW), .LW(LW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .h_up(h_up), .v_up(v_up),
        .char_addr(char_addr), .glyph_line(glyph_line), .up_active(up_active)
    );

    // Hand the memory's code straight to the glyph lookup.
    assign glyph_code = char_code;

    // Load on the last clock of a byte when the next byte is visible.
    assign load = px_last & up_active;

    vga_glyph_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .row_in(glyph_row),
        .de(de), .pixel(pixel)
    );

    // R9
    blank_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_n || !vsync_n) |-> !pixel);
endmodule

// File: tb/tb_vga_text_top.sv
// Near-exhaustive bench: a reduced 4x2-cell geometry, checked every clock
// over several frames, with models of the memory and the glyph lookup.
module tb_vga_text_top;
    localparam int HA = 4, HF = 1, HS = 2, HB = 1;
    localparam int VA = 32, VF = 2, VS = 2, VB = 1;
    localparam int GH = 16;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int FRAME = 8 * HT * VT;
    localparam int AW = $clog2(HA * (VA / GH));
    localparam int LW = $clog2(GH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] char_addr;
    logic [7:0]    char_code = 8'd0;
    logic [7:0]    glyph_code;
    logic [LW-1:0] glyph_line;
    logic [7:0]    glyph_row = 8'd0;
    logic hsync_n, vsync_n, de, pixel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vga_text_top #(
        .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .GLYPH_H(GH)
    ) dut (
        .clk(clk), .rst_n(rst_n), .char_addr(char_addr), .char_code(char_code),
        .glyph_code(glyph_code), .glyph_line(glyph_line), .glyph_row(glyph_row),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .pixel(pixel)
    );

    function automatic logic [7:0] mem_f(int a);
        return 8'((a * 53 + 17) & 255);
    endfunction

    function automatic logic [7:0] font_f(logic [7:0] c, int l);
        return c ^ {c[3:0], c[7:4]} ^ 8'((l * 37 + 90) & 255);
    endfunction

    // One-cycle character memory and one-cycle glyph lookup models.
    always @(posedge clk) begin
        char_code <= mem_f(int'(char_addr));
        glyph_row <= font_f(glyph_code, int'(glyph_line));
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the position t clocks after reset release.
    task automatic check_state(int t);
        int px, h, v, hu, vu, ea, ep;
        bit eact;
        px = t % 8;
        h  = (t / 8) % HT;
        v  = (t / (8 * HT)) % VT;
        if (h == HT - 1) begin hu = 0; vu = (v + 1) % VT; end
        else begin hu = h + 1; vu = v; end
        eact = (h < HA) && (v < VA);
        chk("R2", "hsync_n", int'(hsync_n), (h >= HA + HF && h < HA + HF + HS) ? 0 : 1);
        chk("R4", "vsync_n", int'(vsync_n), (v >= VA + VF && v < VA + VF + VS) ? 0 : 1);
        chk("R5", "de", int'(de), int'(eact));
        ea = (hu < HA && vu < VA) ? (vu / GH) * HA + hu : 0;
        chk("R6", "char_addr", int'(char_addr), ea);
        chk("R7", "glyph_line", int'(glyph_line), vu % GH);
        chk("R7", "glyph_code", int'(glyph_code), int'(char_code));
        if (!eact) chk("R9", "pixel blank", int'(pixel), 0);
        else if (t < 8) chk("R10", "first byte blank", int'(pixel), 0);
        else begin
            ep = int'(font_f(mem_f((v / GH) * HA + h), v % GH) >> (7 - px)) & 1;
            chk("R8", "pixel", int'(pixel), ep);
        end
    endtask

    // Run n clocks from a fresh release, with period and width checks.
    task automatic run_span(int n);
        int hf = -1, vf = -1;
        logic hp = 1'b1, vp = 1'b1;
        for (int t = 0; t < n; t++) begin
            check_state(t);
            if (hp && !hsync_n) begin
                if (hf >= 0) chk("R1", "line period", t - hf, 8 * HT);
                hf = t;
            end
            if (!hp && hsync_n && hf >= 0) chk("R2", "hsync width", t - hf, 8 * HS);
            if (vp && !vsync_n) begin
                if (vf >= 0) chk("R3", "frame period", t - vf, FRAME);
                vf = t;
            end
            if (!vp && vsync_n && vf >= 0) chk("R4", "vsync width", t - vf, 8 * HT * VS);
            hp = hsync_n;
            vp = vsync_n;
            @(negedge clk);
        end
    endtask

    task automatic check_reset_outputs();
        chk("R10", "de in reset", int'(de), 1);
        chk("R10", "hsync_n in reset", int'(hsync_n), 1);
        chk("R10", "vsync_n in reset", int'(vsync_n), 1);
        chk("R10", "pixel in reset", int'(pixel), 0);
        check_state(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_outputs();
        rst_n = 1'b1;
        run_span(2 * FRAME + 500);
        // R10: reset in the middle of a frame restarts from position zero
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_outputs();
        rst_n = 1'b1;
        run_span(FRAME + 300);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule